// File: doc/BRIEF.md
# Initiator Bus Phase Sequencer

This block is the control state machine of an initiator on a shared parallel peripheral bus. It takes one command through the protocol phases in order. The bus starts idle. The initiator then contends for the bus and selects a target. After that the target takes charge and drives a phase code, which moves the transfer through command bytes, data beats, status and messages.

The sequencer checks every phase code the target presents against the phase the bus is in. A code that is not allowed from that phase raises an error and releases the bus. The sequencer keeps a data pointer that counts data beats, plus one saved copy of that pointer. The target can update the saved copy with messages, and can disconnect part way through a transfer. When the target later reselects the initiator, the pointer is reloaded from the saved copy and the data phase carries on from that point.

Contention is decided in a single cycle with fixed priority. The highest device ID that is requesting wins. Competing requesters appear as a bitmap with one bit per device ID.

Top module: `bus_phase_seq`

## Requirements
- R1: After reset, `phase_o` is bus free (code 0), `ptr_o` is 0, and `arb_won_o`, `arb_lost_o`, `cmd_done_o` and `err_o` are all low.
- R2: A start request is latched. It enters arbitration (`phase_o`=1) on the first edge at which the phase is bus free and `bus_busy_i` is low. While `bus_busy_i` is high, the phase stays bus free. From bus free, the only next phases are bus free, arbitration or selection.
- R3: In the arbitration cycle, the initiator wins when no bit of `arb_req_i` is set above position MY_ID. Bits at or below MY_ID, including its own bit, do not block it. A win moves the phase to selection (code 2) and raises `arb_won_o` for one cycle. A loss returns the phase to bus free and raises `arb_lost_o` for one cycle. The two flags are never high together.
- R4: After a loss, the sequencer does not arbitrate again until `bus_busy_i` has been seen high and then low again.
- R5: Target phase codes are command=3, data=4, message=5 and status=6. They are sampled when `code_vld_i` is high in a connected phase. The allowed moves are:
  - from a fresh selection, to command only;
  - from a reselection, to data only;
  - from command, data or message, to data, message or status;
  - from status, to message only.
- R6: Each `xfer_i` pulse during the data phase adds 1 to `ptr_o`. A won arbitration clears the pointer and its saved copy to 0.
- R7: During the message phase, message code 1 copies the pointer into the saved copy. Message code 2 reloads the pointer from the saved copy. Neither message changes the phase. Message code 4 (identify) has no effect.
- R8: Message code 3 (disconnect) saves the current pointer, returns the phase to bus free and does not raise `cmd_done_o`. When `resel_i` is high in bus free after a disconnect, the phase moves to selection and the pointer is reloaded from the saved copy.
- R9: Message code 0 (command complete), received after a status phase, returns the phase to bus free and raises `cmd_done_o` for one cycle. Received with no status phase before it, the same message is treated as an error.
- R10: Any of the following sets `err_o`, forces the phase to bus free and drops the pending start:
  - a phase code that R5 does not allow;
  - a message code of 5 to 7;
  - a completion message with no status phase before it.
  `err_o` stays high until the next entry into arbitration.
- R11: `resel_i` is ignored in bus free when no disconnect is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to run one command |
| bus_busy_i | input | 1 | Another device is using the bus |
| arb_req_i | input | 2**ID_W | Requesting devices, one bit per device ID |
| resel_i | input | 1 | Target reselects this initiator |
| code_vld_i | input | 1 | Target phase code is valid |
| code_i | input | 3 | Target phase code |
| msg_vld_i | input | 1 | Message byte is valid during the message phase |
| msg_i | input | 3 | Message type |
| xfer_i | input | 1 | One data beat has moved |
| phase_o | output | 3 | Current bus phase |
| arb_won_o | output | 1 | Arbitration won (one-cycle pulse) |
| arb_lost_o | output | 1 | Arbitration lost (one-cycle pulse) |
| cmd_done_o | output | 1 | Command complete (one-cycle pulse) |
| err_o | output | 1 | Protocol error flag |
| ptr_o | output | PTR_W | Current data pointer |

## Verification
The bench drives competing requesters above, at and below the initiator's own ID:
- A comparator with the wrong direction would give up the bus to lower IDs.
- A comparator that counted the initiator's own bit would never win.

After a loss, the bench holds the bus idle to show that there is no retry before a busy/free cycle. A design without that hold-off would arbitrate again straight away.

The disconnect case uses a pointer that differs from the saved copy. A design that kept the stale saved value, or that cleared the pointer on reselection, resumes at the wrong beat.

Completion with no status phase, an out-of-order phase code and an unknown message are each shown to set the error and release the bus. A design that let any of them through would report a false completion or stay connected.

// File: rtl/bus_phase_seq.sv
module bus_phase_seq #(
  parameter int ID_W  = 3,
  parameter int MY_ID = 3,
  parameter int PTR_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic                   bus_busy_i,
  input  logic [(1<<ID_W)-1:0]   arb_req_i,
  input  logic                   resel_i,
  input  logic                   code_vld_i,
  input  logic [2:0]             code_i,
  input  logic                   msg_vld_i,
  input  logic [2:0]             msg_i,
  input  logic                   xfer_i,
  output logic [2:0]             phase_o,
  output logic                   arb_won_o,
  output logic                   arb_lost_o,
  output logic                   cmd_done_o,
  output logic                   err_o,
  output logic [PTR_W-1:0]       ptr_o
);
  localparam int NDEV = 1 << ID_W;
  localparam logic [NDEV-1:0] HI_MASK = {NDEV{1'b1}} << (MY_ID + 1);

  localparam logic [2:0] P_FREE = 3'd0, P_ARB = 3'd1, P_SEL = 3'd2, P_CMD = 3'd3,
                         P_DATA = 3'd4, P_MSG = 3'd5, P_STAT = 3'd6;
  localparam logic [2:0] M_DONE = 3'd0, M_SAVE = 3'd1, M_RESTORE = 3'd2,
                         M_DISC = 3'd3, M_IDENT = 3'd4;

  logic [2:0]       phase_q;
  logic             pend_q, hold_q, disc_q, resel_q, stat_q;
  logic             won_q, lost_q, done_q, err_q;
  logic [PTR_W-1:0] ptr_q, save_q;
  logic             legal;

  wire arb_win = ~|(arb_req_i & HI_MASK);

  always_comb begin
    case (phase_q)
      P_SEL:                legal = resel_q ? (code_i == P_DATA) : (code_i == P_CMD);
      P_CMD, P_DATA, P_MSG: legal = (code_i == P_DATA) || (code_i == P_MSG) || (code_i == P_STAT);
      P_STAT:               legal = (code_i == P_MSG);
      default:              legal = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= P_FREE;
      pend_q  <= 1'b0;
      hold_q  <= 1'b0;
      disc_q  <= 1'b0;
      resel_q <= 1'b0;
      stat_q  <= 1'b0;
      won_q   <= 1'b0;
      lost_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      ptr_q   <= '0;
      save_q  <= '0;
    end else begin
      won_q  <= 1'b0;
      lost_q <= 1'b0;
      done_q <= 1'b0;
      if (start_i)    pend_q <= 1'b1;
      if (bus_busy_i) hold_q <= 1'b0;
      case (phase_q)
        P_FREE: begin
          if (resel_i && disc_q) begin
            phase_q <= P_SEL;
            resel_q <= 1'b1;
            disc_q  <= 1'b0;
            ptr_q   <= save_q;
          end else if ((pend_q || start_i) && !bus_busy_i && !hold_q) begin
            phase_q <= P_ARB;
            err_q   <= 1'b0;
          end
        end
        P_ARB: begin
          if (arb_win) begin
            phase_q <= P_SEL;
            won_q   <= 1'b1;
            pend_q  <= 1'b0;
            resel_q <= 1'b0;
            disc_q  <= 1'b0;
            stat_q  <= 1'b0;
            ptr_q   <= '0;
            save_q  <= '0;
          end else begin
            phase_q <= P_FREE;
            lost_q  <= 1'b1;
            hold_q  <= 1'b1;
          end
        end
        default: begin
          if (code_vld_i) begin
            if (legal) begin
              phase_q <= code_i;
              if (code_i == P_STAT) stat_q <= 1'b1;
            end else begin
              phase_q <= P_FREE;
              err_q   <= 1'b1;
              pend_q  <= 1'b0;
            end
          end else if (phase_q == P_DATA && xfer_i) begin
            ptr_q <= ptr_q + 1'b1;
          end else if (phase_q == P_MSG && msg_vld_i) begin
            case (msg_i)
              M_DONE: begin
                phase_q <= P_FREE;
                if (stat_q) done_q <= 1'b1;
                else begin
                  err_q  <= 1'b1;
                  pend_q <= 1'b0;
                end
              end
              M_SAVE:    save_q <= ptr_q;
              M_RESTORE: ptr_q  <= save_q;
              M_DISC: begin
                save_q  <= ptr_q;
                disc_q  <= 1'b1;
                phase_q <= P_FREE;
              end
              M_IDENT: ;
              default: begin
                phase_q <= P_FREE;
                err_q   <= 1'b1;
                pend_q  <= 1'b0;
              end
            endcase
          end
        end
      endcase
    end
  end

  assign phase_o    = phase_q;
  assign arb_won_o  = won_q;
  assign arb_lost_o = lost_q;
  assign cmd_done_o = done_q;
  assign err_o      = err_q;
  assign ptr_o      = ptr_q;

  assert_phase_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o <= P_STAT) else $error("phase code out of range");
  assert_free_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(phase_o) == P_FREE |-> (phase_o == P_FREE || phase_o == P_ARB || phase_o == P_SEL))
    else $error("bad exit from bus free");
  assert_won_lost_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(arb_won_o && arb_lost_o)) else $error("won and lost together");
  assert_won_in_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    arb_won_o |-> phase_o == P_SEL) else $error("won without selection");
  assert_done_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done_o |-> phase_o == P_FREE) else $error("done while connected");
  assert_err_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> phase_o == P_FREE) else $error("error without release");
endmodule

// File: tb/bus_phase_seq_tb.sv
module bus_phase_seq_tb;
  localparam int NDEV = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, bus_busy_i = 0, resel_i = 0, code_vld_i = 0, msg_vld_i = 0, xfer_i = 0;
  logic [NDEV-1:0] arb_req_i = '0;
  logic [2:0] code_i = '0, msg_i = '0;
  logic [2:0] phase_o;
  logic arb_won_o, arb_lost_o, cmd_done_o, err_o;
  logic [11:0] ptr_o;
  int checks = 0, fails = 0;
  bit finished = 0;

  bus_phase_seq u_dut (
    .clk, .rst_n, .start_i, .bus_busy_i, .arb_req_i, .resel_i, .code_vld_i, .code_i,
    .msg_vld_i, .msg_i, .xfer_i, .phase_o, .arb_won_o, .arb_lost_o, .cmd_done_o,
    .err_o, .ptr_o);

  always #2 clk = ~clk;

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic code(logic [2:0] c);
    code_vld_i = 1; code_i = c; step(); code_vld_i = 0;
  endtask

  task automatic msg(logic [2:0] m);
    msg_vld_i = 1; msg_i = m; step(); msg_vld_i = 0;
  endtask

  task automatic xfer(int n);
    for (int i = 0; i < n; i++) begin xfer_i = 1; step(); end
    xfer_i = 0;
  endtask

  task automatic win();
    start_i = 1; arb_req_i = '0; step(); start_i = 0;
    chk("R2 arb entry", phase_o, 1);
    step();
    chk("R3 win sel", phase_o, 2);
    chk("R3 won pulse", arb_won_o, 1);
    chk("R6 ptr cleared", ptr_o, 0);
  endtask

  task automatic t_reset();
    chk("R1 phase", phase_o, 0);
    chk("R1 ptr", ptr_o, 0);
    chk("R1 flags", {arb_won_o, arb_lost_o, cmd_done_o, err_o}, 0);
  endtask

  task automatic t_full_cmd();
    bus_busy_i = 1; start_i = 1; step(); start_i = 0;
    chk("R2 busy holds free", phase_o, 0);
    step();
    chk("R2 busy holds free 2", phase_o, 0);
    bus_busy_i = 0; step();
    chk("R2 pending start arbitrates", phase_o, 1);
    step();
    chk("R3 win", phase_o, 2);
    chk("R3 won pulse", arb_won_o, 1);
    code(3); chk("R5 sel->cmd", phase_o, 3);
    chk("R3 won one cycle", arb_won_o, 0);
    code(4); chk("R5 cmd->data", phase_o, 4);
    xfer(3); chk("R6 ptr count", ptr_o, 3);
    code(6); chk("R5 data->stat", phase_o, 6);
    code(5); chk("R5 stat->msg", phase_o, 5);
    msg(0);
    chk("R9 done free", phase_o, 0);
    chk("R9 done pulse", cmd_done_o, 1);
    step(); chk("R9 done one cycle", cmd_done_o, 0);
  endtask

  task automatic t_lose();
    start_i = 1; step(); start_i = 0;
    chk("R2 arb", phase_o, 1);
    arb_req_i = 8'b0010_0000; step();
    chk("R3 loss free", phase_o, 0);
    chk("R3 lost pulse", arb_lost_o, 1);
    chk("R3 no won", arb_won_o, 0);
    arb_req_i = '0;
    for (int i = 0; i < 3; i++) begin
      step(); chk("R4 no retry while idle", phase_o, 0);
    end
    bus_busy_i = 1; step(); chk("R4 busy", phase_o, 0);
    bus_busy_i = 0; step(); chk("R4 retry after free", phase_o, 1);
    arb_req_i = 8'b0000_1010; step();
    chk("R3 lower and own ids do not block", phase_o, 2);
    chk("R3 won", arb_won_o, 1);
    arb_req_i = '0;
    code(3); code(6); code(5); msg(0);
    chk("R9 done", cmd_done_o, 1);
  endtask

  task automatic t_disc();
    resel_i = 1; step(); resel_i = 0;
    chk("R11 resel ignored", phase_o, 0);
    win();
    code(3); code(4); xfer(2);
    chk("R6 ptr 2", ptr_o, 2);
    code(5); msg(1);
    chk("R7 save keeps msg phase", phase_o, 5);
    msg(4); chk("R7 identify no effect", phase_o, 5);
    chk("R7 identify ptr", ptr_o, 2);
    code(4); xfer(3);
    chk("R6 ptr 5", ptr_o, 5);
    code(5); msg(2);
    chk("R7 restore", ptr_o, 2);
    code(4); xfer(1);
    code(5); msg(3);
    chk("R8 disc free", phase_o, 0);
    chk("R8 no done", cmd_done_o, 0);
    step(); step();
    chk("R8 stays free", phase_o, 0);
    resel_i = 1; step(); resel_i = 0;
    chk("R8 reselect", phase_o, 2);
    chk("R8 ptr restored", ptr_o, 3);
    code(4); chk("R5 resel->data", phase_o, 4);
    chk("R5 no err", err_o, 0);
    xfer(1); chk("R8 resume count", ptr_o, 4);
    code(6); code(5); msg(0);
    chk("R9 done after resume", cmd_done_o, 1);
  endtask

  task automatic t_err();
    win();
    code(4);
    chk("R10 illegal sel->data err", err_o, 1);
    chk("R10 illegal release", phase_o, 0);
    step(); chk("R10 no pending retry", phase_o, 0);
    chk("R10 err sticky", err_o, 1);
    win();
    chk("R10 err cleared", err_o, 0);
    code(3); code(6); code(4);
    chk("R10 stat->data err", err_o, 1);
    chk("R10 release 2", phase_o, 0);
    win();
    code(3); code(5); msg(0);
    chk("R9 done without status err", err_o, 1);
    chk("R9 no done", cmd_done_o, 0);
    chk("R9 release", phase_o, 0);
    win();
    code(3); code(5); msg(7);
    chk("R10 unknown msg err", err_o, 1);
    chk("R10 unknown msg release", phase_o, 0);
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog got=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    step(); step();
    t_reset();
    rst_n = 1; step();
    t_full_cmd();
    t_lose();
    t_disc();
    t_err();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule